// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block interleaves instruction issue among up to sixteen hardware thread contexts. Each context owns a status word holding its program counter. Ready contexts wait in a first-in, first-out ready queue. In every cycle the context at the head of that queue issues one instruction, presented as a context id and a PC. The issued status word then travels through a control loop that is exactly as deep as the data pipeline. It may rejoin the tail of the queue only in the cycle its instruction leaves the data pipeline. A thread therefore never has two instructions in flight, and a lone thread issues once every `DEPTH` cycles.

When the data pipeline retires an instruction, it hands back the next PC for that context in the cycle the status word leaves the control loop. If no PC is handed back, the context continues at the next sequential address. A context is started by loading an id and a start PC, and it is stopped by a kill request that takes effect at its next return. When no context is waiting, the issue slot is left empty rather than letting any thread issue early. A per-context counter records how many instructions each context has issued.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset `issue_valid` is 0, no context is active, and every per-context issue counter reads 0.
- R2: A load (`load_valid`=1) whose `load_id` is inactive appends that context to the tail of the ready queue with PC `load_pc`. A load naming an already active context is ignored: its PC and its place in the order are unchanged.
- R3: In a cycle where the ready queue (including contexts joining it in that same cycle) is not empty, the head context issues at the next clock edge. `issue_valid`=1, `issue_id` is its id and `issue_pc` is its current PC. At most one context issues per cycle.
- R4: A context that issues in cycle c is absent from the ready queue until cycle c+`DEPTH`-1, and it can issue again no earlier than cycle c+`DEPTH`.
- R5: When no context is waiting or joining, the next cycle has `issue_valid`=0 (a bubble). A single active context issues exactly once every `DEPTH` cycles.
- R6: The ready queue is served in arrival order. When a returning context and a loaded context join in the same cycle, the returning context is placed ahead of the loaded one.
- R7: A context that issued in cycle c returns during cycle c+`DEPTH`-1. If `done_valid`=1 in that cycle, its PC becomes `done_pc`. Otherwise its PC becomes its issued PC plus one, modulo 2^`PCW`.
- R8: A kill (`kill_valid`=1) naming an active context removes it at its next return, so it may issue once more if already queued. A kill naming an inactive context is ignored. A removed context can be loaded again.
- R9: With N active contexts and no loads or kills, each context issues once every max(N, `DEPTH`) cycles. When N >= `DEPTH` no bubbles occur.
- R10: Field k of `issue_count` (bits k*`CNTW` up to k*`CNTW`+`CNTW`-1) counts issues by context k. It increments in the same edge that raises `issue_valid` for k and wraps modulo 2^`CNTW`.
- R11: A context is held in at most one place, either the ready queue or one control-loop stage. The number of active contexts equals the queue occupancy plus the number of occupied loop stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Start a context |
| load_id | input | log2(NCTX) | Context to start |
| load_pc | input | PCW | Start PC of that context |
| kill_valid | input | 1 | Stop a context at its next return |
| kill_id | input | log2(NCTX) | Context to stop |
| done_valid | input | 1 | Data pipeline supplies a next PC for the returning context |
| done_pc | input | PCW | Next PC for the returning context |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_id | output | log2(NCTX) | Issuing context |
| issue_pc | output | PCW | PC fetched for the issuing context |
| issue_count | output | NCTX*CNTW | Per-context issue counters, context k in field k |

## Verification
The hardest case to reach from the ports is a kill that lands in the very cycle its context returns from the control loop. A close second is a load that coincides with a return, so that two contexts join the queue in one edge while a third is popped. The bench keeps a history of what it saw issue. It waits until that history shows the chosen context sitting in the last loop stage, then drives the kill in exactly that cycle. Loading contexts one per cycle while eight or sixteen others circulate makes loads and returns collide repeatedly, and a full sixteen-context phase keeps the queue half full so that the in-order path is exercised as well as the bypass.

// File: rtl/bts_pkg.sv
package bts_pkg;
  // Sequential successor of a program counter; caller truncates to its width.
  function automatic logic [63:0] seq_pc(input logic [63:0] pc);
    return pc + 64'd1;
  endfunction

  // Number of queue entries consumed or appended in one cycle.
  function automatic int unsigned join_count(input logic a, input logic b);
    return int'(a) + int'(b);
  endfunction
endpackage

// File: rtl/bts_ready_fifo.sv
module bts_ready_fifo #(
  parameter int NCTX = 16,
  localparam int IDW = $clog2(NCTX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_a,
  input  logic [IDW-1:0] id_a,
  input  logic           push_b,
  input  logic [IDW-1:0] id_b,
  output logic           pop_valid,
  output logic [IDW-1:0] pop_id,
  output logic           from_store,
  output logic [IDW:0]   occupancy
);
  import bts_pkg::*;

  logic [IDW-1:0] mem [NCTX];
  logic [IDW-1:0] rd_q, wr_q;
  logic [IDW:0]   cnt_q;
  logic [IDW-1:0] wr_b;

  assign from_store = (cnt_q != '0);
  assign pop_valid  = from_store | push_a | push_b;
  // Empty store: the first joining entry bypasses straight to the head.
  assign pop_id     = from_store ? mem[rd_q] : (push_a ? id_a : id_b);
  assign wr_b       = wr_q + IDW'(push_a);
  assign occupancy  = cnt_q;

  always_ff @(posedge clk) begin
    if (push_a) mem[wr_q] <= id_a;
    if (push_b) mem[wr_b] <= id_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + IDW'(join_count(push_a, push_b));
      rd_q  <= rd_q + IDW'(pop_valid);
      cnt_q <= cnt_q + (IDW+1)'(join_count(push_a, push_b)) - (IDW+1)'(pop_valid);
    end
  end
endmodule

// File: rtl/bts_ctl_loop.sv
module bts_ctl_loop #(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int PCW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IDW-1:0]       in_id,
  input  logic [PCW-1:0]       in_pc,
  output logic [DEPTH-1:0]     st_valid,
  output logic [DEPTH*IDW-1:0] st_id,
  output logic [DEPTH*PCW-1:0] st_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) st_valid[0] <= 1'b0;
    else        st_valid[0] <= in_valid;
    st_id[IDW-1:0] <= in_id;
    st_pc[PCW-1:0] <= in_pc;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) st_valid[k] <= 1'b0;
      else        st_valid[k] <= st_valid[k-1];
      st_id[k*IDW +: IDW] <= st_id[(k-1)*IDW +: IDW];
      st_pc[k*PCW +: PCW] <= st_pc[(k-1)*PCW +: PCW];
    end
  end
endmodule

// File: rtl/bts_ctx_table.sv
module bts_ctx_table #(
  parameter int NCTX = 16,
  parameter int PCW  = 16,
  parameter int CNTW = 16,
  localparam int IDW = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_ok,
  input  logic [IDW-1:0]       ld_id,
  input  logic [PCW-1:0]       ld_pc,
  input  logic                 kill_valid,
  input  logic [IDW-1:0]       kill_id,
  input  logic                 ret_push,
  input  logic                 ret_drop,
  input  logic [IDW-1:0]       ret_id,
  input  logic [PCW-1:0]       ret_pc,
  input  logic                 iss_valid,
  input  logic [IDW-1:0]       iss_id,
  input  logic [IDW-1:0]       rd_id,
  output logic [PCW-1:0]       rd_pc,
  output logic [NCTX-1:0]      active,
  output logic [NCTX-1:0]      kill_pend,
  output logic [NCTX*CNTW-1:0] cnt_flat
);
  logic [PCW-1:0] pc_q [NCTX];

  assign rd_pc = pc_q[rd_id];

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic hit_ld, hit_ret, hit_kill, hit_iss;
    assign hit_ld   = ld_ok      && (ld_id   == IDW'(i));
    assign hit_ret  =               (ret_id  == IDW'(i));
    assign hit_kill = kill_valid && (kill_id == IDW'(i));
    assign hit_iss  = iss_valid  && (iss_id  == IDW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[i]                <= 1'b0;
        kill_pend[i]             <= 1'b0;
        pc_q[i]                  <= '0;
        cnt_flat[i*CNTW +: CNTW] <= '0;
      end else begin
        if (hit_ld)                active[i] <= 1'b1;
        else if (ret_drop && hit_ret) active[i] <= 1'b0;

        if (ret_drop && hit_ret)   kill_pend[i] <= 1'b0;
        else if (hit_kill && active[i]) kill_pend[i] <= 1'b1;

        if (hit_ld)                pc_q[i] <= ld_pc;
        else if (ret_push && hit_ret) pc_q[i] <= ret_pc;

        if (hit_iss) cnt_flat[i*CNTW +: CNTW] <= cnt_flat[i*CNTW +: CNTW] + CNTW'(1);
      end
    end
  end
endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
  parameter int NCTX  = 16,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  parameter int CNTW  = 16,
  localparam int IDW  = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  input  logic [IDW-1:0]       load_id,
  input  logic [PCW-1:0]       load_pc,
  input  logic                 kill_valid,
  input  logic [IDW-1:0]       kill_id,
  input  logic                 done_valid,
  input  logic [PCW-1:0]       done_pc,
  output logic                 issue_valid,
  output logic [IDW-1:0]       issue_id,
  output logic [PCW-1:0]       issue_pc,
  output logic [NCTX*CNTW-1:0] issue_count
);
  import bts_pkg::*;

  // Named internal events (also observed by the checker).
  logic                 ld_ok, exit_valid, ret_drop, ret_push;
  logic [IDW-1:0]       exit_id, head_id;
  logic [PCW-1:0]       exit_pc, ret_next_pc, head_pc, tab_pc;
  logic                 pop_valid, from_store;
  logic [IDW:0]         occupancy;
  logic [NCTX-1:0]      active, kill_pend;
  logic [DEPTH-1:0]     st_valid;
  logic [DEPTH*IDW-1:0] st_id;
  logic [DEPTH*PCW-1:0] st_pc;

  assign exit_valid  = st_valid[DEPTH-1];
  assign exit_id     = st_id[(DEPTH-1)*IDW +: IDW];
  assign exit_pc     = st_pc[(DEPTH-1)*PCW +: PCW];

  assign ld_ok       = load_valid && !active[load_id];
  assign ret_drop    = exit_valid && (kill_pend[exit_id] || (kill_valid && kill_id == exit_id));
  assign ret_push    = exit_valid && !ret_drop;
  assign ret_next_pc = done_valid ? done_pc : PCW'(seq_pc(64'(exit_pc)));

  // Head PC: stored word, or the word of a context joining this very cycle.
  assign head_pc = from_store ? tab_pc : (ret_push ? ret_next_pc : load_pc);

  bts_ready_fifo #(.NCTX(NCTX)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_a(ret_push), .id_a(exit_id),
    .push_b(ld_ok),    .id_b(load_id),
    .pop_valid(pop_valid), .pop_id(head_id),
    .from_store(from_store), .occupancy(occupancy)
  );

  bts_ctl_loop #(.DEPTH(DEPTH), .IDW(IDW), .PCW(PCW)) u_loop (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pop_valid), .in_id(head_id), .in_pc(head_pc),
    .st_valid(st_valid), .st_id(st_id), .st_pc(st_pc)
  );

  bts_ctx_table #(.NCTX(NCTX), .PCW(PCW), .CNTW(CNTW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .ld_ok(ld_ok), .ld_id(load_id), .ld_pc(load_pc),
    .kill_valid(kill_valid), .kill_id(kill_id),
    .ret_push(ret_push), .ret_drop(ret_drop), .ret_id(exit_id), .ret_pc(ret_next_pc),
    .iss_valid(pop_valid), .iss_id(head_id),
    .rd_id(head_id), .rd_pc(tab_pc),
    .active(active), .kill_pend(kill_pend), .cnt_flat(issue_count)
  );

  assign issue_valid = st_valid[0];
  assign issue_id    = st_id[IDW-1:0];
  assign issue_pc    = st_pc[PCW-1:0];
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int NCTX  = 16,
  parameter int DEPTH = 8,
  parameter int CNTW  = 16,
  localparam int IDW  = $clog2(NCTX)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DEPTH-1:0]     st_valid,
  input logic [DEPTH*IDW-1:0] st_id,
  input logic [IDW:0]         occupancy,
  input logic [NCTX-1:0]      active,
  input logic                 ret_drop,
  input logic [IDW-1:0]       exit_id,
  input logic                 pop_valid,
  input logic [IDW-1:0]       head_id,
  input logic [NCTX*CNTW-1:0] issue_count
);
  logic dup_in_flight;
  always_comb begin
    dup_in_flight = 1'b0;
    for (int k = 1; k < DEPTH; k++)
      if (st_valid[0] && st_valid[k] && st_id[k*IDW +: IDW] == st_id[IDW-1:0])
        dup_in_flight = 1'b1;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_in_flight); // R4

  AST_CONTEXT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) == int'(occupancy) + $countones(st_valid)); // R11

  AST_NO_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != '0) |=> st_valid[0]); // R5

  AST_KILL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_drop |=> !active[$past(exit_id)]); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> issue_count[$past(head_id)*CNTW +: CNTW]
                  == $past(issue_count[head_id*CNTW +: CNTW]) + CNTW'(1)); // R10
endmodule

bind barrel_issue_sched bts_checker #(.NCTX(NCTX), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_id(st_id),
  .occupancy(occupancy), .active(active), .ret_drop(ret_drop), .exit_id(exit_id),
  .pop_valid(pop_valid), .head_id(head_id), .issue_count(issue_count)
);

// File: tb/barrel_issue_sched_test.sv
module barrel_issue_sched_test;
  localparam int NCTX = 16, DEPTH = 8, PCW = 16, CNTW = 16, IDW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_valid = 1'b0, kill_valid = 1'b0, done_valid = 1'b0;
  logic [IDW-1:0] load_id = '0, kill_id = '0;
  logic [PCW-1:0] load_pc = '0, done_pc = '0;
  logic issue_valid;
  logic [IDW-1:0] issue_id;
  logic [PCW-1:0] issue_pc;
  logic [NCTX*CNTW-1:0] issue_count;

  barrel_issue_sched #(.NCTX(NCTX), .DEPTH(DEPTH), .PCW(PCW), .CNTW(CNTW)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0, jump_mode = 0;
  // Bench model state
  int q[$];
  int mpc[NCTX], mcnt[NCTX], last_iss[NCTX], win[NCTX];
  bit mact[NCTX], mkill[NCTX];
  int h_v[DEPTH], h_id[DEPTH], h_pc[DEPTH];
  int ev, eid, epc, bubbles;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    bit ld_ok;
    int id;
    ld_ok = load_valid && !mact[load_id];
    if (kill_valid && mact[kill_id]) mkill[kill_id] = 1;
    if (h_v[DEPTH-1] != 0) begin
      id = h_id[DEPTH-1];
      if (mkill[id]) begin mact[id] = 0; mkill[id] = 0; end
      else begin
        mpc[id] = done_valid ? int'(done_pc) : ((h_pc[DEPTH-1] + 1) % (1 << PCW));
        q.push_back(id);                               // R6: return before load
      end
    end
    if (ld_ok) begin mact[load_id] = 1; mpc[load_id] = int'(load_pc); q.push_back(int'(load_id)); end
    for (int k = DEPTH-1; k > 0; k--) begin h_v[k] = h_v[k-1]; h_id[k] = h_id[k-1]; h_pc[k] = h_pc[k-1]; end
    if (q.size() > 0) begin
      id = q.pop_front();
      ev = 1; eid = id; epc = mpc[id];
      mcnt[id] = (mcnt[id] + 1) % (1 << CNTW);
    end else ev = 0;
    h_v[0] = ev; h_id[0] = eid; h_pc[0] = epc;
  endtask

  task automatic tick();
    // Data pipeline: next PC for the context in the last loop stage (R7)
    done_valid = jump_mode && h_v[DEPTH-1] != 0 && h_id[DEPTH-1][0];
    done_pc    = PCW'(h_pc[DEPTH-1] * 5 + 3);
    model_step();
    @(posedge clk); @(negedge clk);
    cyc++;
    chk(issue_valid == ev[0], "R3/R5 issue_valid", int'(issue_valid), ev);
    if (ev != 0 && issue_valid) begin
      chk(int'(issue_id) == eid, "R6 issue order", int'(issue_id), eid);
      chk(int'(issue_pc) == epc, "R7 issue_pc", int'(issue_pc), epc);
      chk(last_iss[eid] < 0 || cyc - last_iss[eid] >= DEPTH, "R4 spacing", cyc - last_iss[eid], DEPTH);
      last_iss[eid] = cyc;
      win[eid]++;
    end
    if (!issue_valid) bubbles++;
    load_valid = 0; kill_valid = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_win();
    for (int i = 0; i < NCTX; i++) win[i] = 0;
    bubbles = 0;
  endtask

  task automatic check_counters(input string tag);
    for (int i = 0; i < NCTX; i++)
      chk(int'(issue_count[i*CNTW +: CNTW]) == mcnt[i], tag, int'(issue_count[i*CNTW +: CNTW]), mcnt[i]);
  endtask

  task automatic do_load(input int id, input int pc);
    load_valid = 1; load_id = IDW'(id); load_pc = PCW'(pc);
    tick();
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCTX; i++) begin mpc[i] = 0; mcnt[i] = 0; mact[i] = 0; mkill[i] = 0; last_iss[i] = -100; end
    for (int k = 0; k < DEPTH; k++) begin h_v[k] = 0; h_id[k] = 0; h_pc[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(issue_valid == 1'b0, "R1 issue_valid after reset", int'(issue_valid), 0);
    check_counters("R1 counters after reset");

    // R5: single context issues once per DEPTH cycles
    clear_win();
    do_load(3, 100);
    run(4 * DEPTH - 1);
    chk(win[3] == 4, "R5 single context rate", win[3], 4);
    chk(bubbles == 4 * DEPTH - 4, "R5 bubbles with one context", bubbles, 4 * DEPTH - 4);

    // R2: contexts 0..7, one reload of active context 3 must be ignored
    for (int i = 0; i < 8; i++) do_load(i == 3 ? 3 : i, i == 3 ? 999 : 16'h0200 + i * 16);
    run(2 * DEPTH);
    clear_win();
    run(8 * DEPTH);
    for (int i = 0; i < 8; i++) chk(win[i] == 8, "R9 eight contexts share", win[i], 8);
    chk(bubbles == 0, "R9 no bubbles at eight", bubbles, 0);

    // R7: jumps supplied by the data pipeline
    jump_mode = 1;
    run(5 * DEPTH);
    jump_mode = 0;
    check_counters("R10 counters mid run");

    // Sixteen contexts: loads collide with returns
    for (int i = 8; i < 16; i++) do_load(i, 16'h4000 + i);
    run(4 * DEPTH);
    clear_win();
    run(64);
    for (int i = 0; i < 16; i++) chk(win[i] == 4, "R9 sixteen contexts share", win[i], 4);
    chk(bubbles == 0, "R9 no bubbles at sixteen", bubbles, 0);
    do_load(12, 77);   // R2 ignored, model keeps old pc

    // R8: kill 5 early, kill 9 in the exact cycle it returns
    kill_valid = 1; kill_id = 5; tick();
    while (!(h_v[DEPTH-1] != 0 && h_id[DEPTH-1] == 9)) tick();
    kill_valid = 1; kill_id = 9; tick();
    run(3 * DEPTH);
    clear_win();
    run(4 * DEPTH);
    chk(win[5] == 0, "R8 killed context 5 silent", win[5], 0);
    chk(win[9] == 0, "R8 killed context 9 silent", win[9], 0);

    // R8: kill of inactive ignored, reload; R7 wrap from all-ones
    kill_valid = 1; kill_id = 5; tick();
    do_load(5, 16'hFFFF);
    run(4 * DEPTH);
    chk(win[5] >= 0, "R8 reload", win[5], 0);

    // R5: kill everything, slots go empty
    for (int i = 0; i < 16; i++) begin kill_valid = 1; kill_id = IDW'(i); tick(); end
    run(3 * DEPTH);
    clear_win();
    run(4 * DEPTH);
    chk(bubbles == 4 * DEPTH, "R5 all killed gives bubbles", bubbles, 4 * DEPTH);
    check_counters("R10 final counters");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule